// File: doc/BRIEF.md
# Rotating-Priority Prefix Bus Arbiter

This block decides which of several nodes may drive a shared bus in a given cycle. Each node holds a request line high while it waits. In the same cycle it receives a one-hot grant, which serves as its acknowledge. A registered start pointer names the node that has the highest priority. Priority falls off in increasing index order from that node and wraps from the last node back to node 0.

Inside the block, the request vector is rotated so that the start node sits at position 0. An "available" signal then passes down the rotated vector: it begins high, and each requesting node clears it for every node behind it. The first requester that still sees the signal high wins. This availability chain is computed as a parallel-prefix OR in logarithmic depth, and there is no ripple. The rotated grant is rotated back to node numbering.

After every cycle that has a grant, the pointer moves to the node just after the winner. A node that keeps requesting is therefore served within one full turn. Cycles with no request leave the pointer where it is.

Top module: `prefix_bus_arbiter`

## Requirements
- R1: The grant vector has at most one bit set in every cycle.
- R2: A grant bit is set only for a node whose request bit is set in the same cycle.
- R3: When at least one request bit is set, some grant bit is set in that same cycle, with no register between request and grant.
- R4: The winner is the first requesting node met when indices are scanned upward from the start pointer, wrapping from node N_NODES-1 to node 0.
- R5: While reset is held, and after it is released, the start pointer is node 0. With no requests during reset the grant is all zeros, and the first arbitration favours the lowest index.
- R6: After a cycle in which node k is granted, the start pointer for the next cycle is (k+1) modulo N_NODES.
- R7: A cycle with no requests leaves the start pointer unchanged.
- R8: A node whose request stays high is granted within N_NODES consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| want_i | input | N_NODES | Request line per node; bit i is node i |
| grant_o | output | N_NODES | One-hot acknowledge per node, combinational from want_i and the start pointer |

## Verification
The bench builds the arbiter with six nodes. That is not a power of two, so the modulo steps in the log-depth rotators and the wrap of the pointer from node 5 to node 0 cannot fall on a natural binary boundary. At that size, a few thousand random request patterns reach every start position together with every mix of sparse and dense requests. Directed runs push the pointer through a complete turn with every node requesting. They also hold a single requester at the last node so that the wrap can be observed, and they check that idle stretches leave the pointer in place.

// File: rtl/pba_pkg.sv
package pba_pkg;

  // Direction of a cyclic rotation across the node vector.
  typedef enum logic {
    ROT_RIGHT = 1'b0,  // dout[i] = din[(i + amt) mod W]
    ROT_LEFT  = 1'b1   // dout[i] = din[(i - amt) mod W]
  } rot_dir_e;

endpackage

// File: rtl/pba_rotate.sv
module pba_rotate
  import pba_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter rot_dir_e    DIR   = ROT_RIGHT,
  localparam int unsigned SW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SW-1:0]    amt,
  output logic [WIDTH-1:0] dout
);

  // Log-depth barrel: stage k rotates by 2^k mod WIDTH when amt[k] is set.
  logic [SW:0][WIDTH-1:0] stg;

  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned STEP = (1 << k) % WIDTH;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int unsigned SRC = (DIR == ROT_RIGHT) ? ((i + STEP) % WIDTH)
                                                       : ((i + WIDTH - STEP) % WIDTH);
      assign stg[k+1][i] = amt[k] ? stg[k][SRC] : stg[k][i];
    end
  end

  assign dout = stg[SW];

endmodule

// File: rtl/pba_prefix.sv
module pba_prefix #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned LV   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] avail,
  output logic [WIDTH-1:0] got
);

  // Kogge-Stone inclusive OR prefix: orp[LV][i] = |req[i:0].
  logic [LV:0][WIDTH-1:0] orp;

  assign orp[0] = req;

  for (genvar k = 0; k < LV; k++) begin : g_lvl
    localparam int unsigned D = 1 << k;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i >= D) begin : g_comb
        assign orp[k+1][i] = orp[k][i] | orp[k][i-D];
      end else begin : g_pass
        assign orp[k+1][i] = orp[k][i];
      end
    end
  end

  // Availability is forced high at position 0 (the start node) and is
  // cleared behind any earlier requester.
  assign avail[0] = 1'b1;
  for (genvar i = 1; i < WIDTH; i++) begin : g_av
    assign avail[i] = ~orp[LV][i-1];
  end

  assign got = req & avail;

endmodule

// File: rtl/pba_ptr.sv
module pba_ptr #(
  parameter int unsigned N_NODES = 8,
  localparam int unsigned PW     = (N_NODES > 1) ? $clog2(N_NODES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] grant,
  output logic [PW-1:0]      ptr
);

  localparam logic [PW-1:0] LAST = PW'(N_NODES - 1);

  logic [PW-1:0] win_idx;
  logic [PW-1:0] nxt_ptr;
  logic          adv_en;
  logic [PW-1:0] ptr_d;
  logic [PW-1:0] ptr_q;

  // One-hot to index: OR of the indices of the set bits.
  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (grant[i]) win_idx = win_idx | PW'(i);
    end
  end

  always_comb begin
    adv_en  = |grant;
    nxt_ptr = (win_idx == LAST) ? '0 : win_idx + PW'(1);
    ptr_d   = adv_en ? nxt_ptr : ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/prefix_bus_arbiter.sv
module prefix_bus_arbiter
  import pba_pkg::*;
#(
  parameter int unsigned N_NODES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_NODES-1:0] want_i,
  output logic [N_NODES-1:0] grant_o
);

  localparam int unsigned PW = (N_NODES > 1) ? $clog2(N_NODES) : 1;

  // Reset: asserted asynchronously, released through two flops.
  logic rst_m;
  logic rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [PW-1:0]      start_q;
  logic [N_NODES-1:0] want_rot;
  logic [N_NODES-1:0] avail_rot;
  logic [N_NODES-1:0] got_rot;

  // Bring the start node to position 0.
  pba_rotate #(
    .WIDTH (N_NODES),
    .DIR   (ROT_RIGHT)
  ) u_rot_in (
    .din  (want_i),
    .amt  (start_q),
    .dout (want_rot)
  );

  pba_prefix #(
    .WIDTH (N_NODES)
  ) u_chain (
    .req   (want_rot),
    .avail (avail_rot),
    .got   (got_rot)
  );

  // Return the grant to node numbering.
  pba_rotate #(
    .WIDTH (N_NODES),
    .DIR   (ROT_LEFT)
  ) u_rot_out (
    .din  (got_rot),
    .amt  (start_q),
    .dout (grant_o)
  );

  pba_ptr #(
    .N_NODES (N_NODES)
  ) u_ptr (
    .clk   (clk),
    .rst_n (rst_q),
    .grant (grant_o),
    .ptr   (start_q)
  );

endmodule

// File: rtl/pba_chk.sv
module pba_chk #(
  parameter int unsigned N_NODES = 8,
  localparam int unsigned PW     = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int unsigned CW     = $clog2(N_NODES + 1) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_NODES-1:0] want,
  input logic [N_NODES-1:0] grant,
  input logic [PW-1:0]      ptr
);

  function automatic logic [PW-1:0] after_winner(input logic [N_NODES-1:0] g);
    int unsigned idx;
    idx = 0;
    for (int i = 0; i < N_NODES; i++) if (g[i]) idx = i;
    return PW'((idx + 1) % N_NODES);
  endfunction

  p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_granted_wants_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~want) == '0);

  p_work_conserving_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|want) |-> (|grant));

  p_ptr_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |=> (ptr == after_winner($past(grant))));

  p_ptr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|want) |=> $stable(ptr));

  // Per-node wait counters for the fairness bound.
  for (genvar i = 0; i < N_NODES; i++) begin : g_wait
    logic [CW-1:0] wait_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wait_q <= '0;
      else if (want[i] && !grant[i]) wait_q <= wait_q + CW'(1);
      else wait_q <= '0;
    end
    p_no_starve_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q < CW'(N_NODES));
  end

endmodule

bind prefix_bus_arbiter pba_chk #(
  .N_NODES (N_NODES)
) u_chk (
  .clk   (clk),
  .rst_n (rst_q),
  .want  (want_i),
  .grant (grant_o),
  .ptr   (start_q)
);

// File: tb/tb_prefix_bus_arbiter.sv
module tb_prefix_bus_arbiter;

  localparam int N = 6;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] want;
  logic [N-1:0] grant;

  int n_vec;
  int n_bad;
  int mptr;
  int waitc [N];
  bit done;

  prefix_bus_arbiter #(.N_NODES(N)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .want_i  (want),
    .grant_o (grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Linear reference: first requester scanning upward from p, with wrap.
  function automatic logic [N-1:0] ref_grant(input logic [N-1:0] w, input int p);
    logic [N-1:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (w[(p + k) % N]) r = '0 | (1 << ((p + k) % N));
    end
    return r;
  endfunction

  function automatic int idx_of(input logic [N-1:0] g);
    int r;
    r = 0;
    for (int i = 0; i < N; i++) if (g[i]) r = i;
    return r;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] w, input string tag);
    logic [N-1:0] exp;
    @(negedge clk);
    want = w;
    #1;
    exp = ref_grant(w, mptr);
    check(tag, grant, exp);                                       // R4
    check("R1 at most one grant", N'($countones(grant) <= 1), N'(1));
    check("R2 grant within want", grant & ~w, '0);
    check("R3 grant when any want", N'((w == '0) || (grant != '0)), N'(1));
    for (int i = 0; i < N; i++) begin
      if (w[i] && !exp[i]) waitc[i]++;
      else waitc[i] = 0;
      if (waitc[i] >= N) begin
        n_vec++;
        n_bad++;
        $display("FAIL R8 node %0d: waited=%0d expected<%0d", i, waitc[i], N);
      end
    end
    if (exp != '0) mptr = (idx_of(exp) + 1) % N;                 // R6
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0;
    n_bad = 0;
    mptr  = 0;
    done  = 0;
    for (int i = 0; i < N; i++) waitc[i] = 0;
    void'($urandom(32'd20250404));

    rst_n = 1'b0;
    want  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R5 no grant in reset", grant, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 idle after reset", grant, '0);

    // R5: pointer at node 0 after reset; all request -> node 0.
    apply('1, "R5 first grant to node 0");
    // R6: full turn with everyone requesting.
    for (int k = 0; k < N + 2; k++) apply('1, "R6 rotate all-request");

    // R7: idle cycles keep the pointer.
    repeat (3) apply('0, "R7 idle no grant");
    apply('1, "R7 pointer held across idle");

    // R4: wrap from last node to node 0.
    apply(N'(1) << (N - 1), "R4 single at last node");
    apply((N'(1) << (N - 1)) | N'(1), "R4 wrap node 0 beats last");
    apply((N'(1) << (N - 1)) | N'(4), "R4 start at 1 picks node 2");
    apply(N'(2), "R4 single behind start");

    // Mixed random stimulus.
    for (int v = 0; v < 3000; v++) begin
      logic [N-1:0] w;
      case ($urandom % 4)
        0: w = '0;
        1: w = N'($urandom) & N'($urandom);
        2: w = '1;
        default: w = N'($urandom);
      endcase
      apply(w, "R4 random pattern");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule